// File: doc/BRIEF.md
# Per-CPU Interrupt Presentation Unit

This block sits between a set of interrupt sources and one processor. It holds at most one interrupt that is waiting to be taken, together with the priority of that interrupt. Sources offer interrupts as a number and a priority. The unit either takes an offer into its single slot or sends it straight back with a reject strobe. When a better offer arrives, the interrupt it displaces is handed back to its source, so nothing is queued here. The unit also carries a software-written priority for an inter-processor interrupt. That interrupt competes for the slot under the same rules, using a fixed source number.

The processor drives five single-cycle operations: take the pending interrupt, signal end of service with a full status word, change its current priority, write the inter-processor priority, and read the state without side effects. The unit drives one interrupt line. Toward the sources it emits three strobes, each lasting one cycle: reject (with a number), end of service (with a number), and a request that every source re-offer what it holds. Lower numeric priority values are more favoured. The all-ones value means nothing is pending or nothing is allowed.

Top module: `irq_presenter`

## Requirements
- R1: After reset the status word reads all zeros, the inter-processor priority reads all ones, the interrupt line is low, and the hidden pending priority is all ones, so a take issued right after reset loads all ones into the current priority.
- R2: The status word places the current priority in its upper PRIO_W bits and the pending source number in its lower NUM_W bits. A read returns the status word and the inter-processor priority on rd_word and rd_mfrr one cycle after the strobe, with rd_valid high, and changes no state.
- R3: An offer is refused when its priority is not below the current priority, or when a number is pending whose priority is not above the offered one. A refusal emits reject with the offered number one cycle later and leaves the state unchanged.
- R4: An accepted offer replaces the pending number and priority and raises the line. A displaced number is rejected only if a source supplied it; a displaced inter-processor interrupt is not rejected.
- R5: A take returns the status word as it stood before the take, then lowers the line, copies the pending priority into the current priority, empties the source field and sets the pending priority to all ones.
- R6: Writing a current priority (op_data[PRIO_W-1:0]) that is more favoured than the old one, while a number is pending at a priority not more favoured than the new value, empties the slot, lowers the line and rejects a source-supplied number.
- R7: Writing a current priority that is not more favoured than the old one, while no number is pending, pulses the re-offer strobe. If the inter-processor priority is below the new current priority, the inter-processor interrupt is also loaded in that same operation.
- R8: End of service copies op_data bits [WORD_W-1:NUM_W] into the current priority and emits the end-of-service strobe with op_data[NUM_W-1:0]. If no number is pending, it also pulses the re-offer strobe and runs the inter-processor check against the new current priority.
- R9: Writing an inter-processor priority (op_data[PRIO_W-1:0]) below the current priority loads source number IPI_NUM (2) with that priority and raises the line. Any source-supplied number it displaces is rejected.
- R10: The inter-processor check leaves the slot unchanged when a number is already pending at a priority not above the inter-processor priority.
- R11: The caller issues at most one operation or offer per cycle. The interrupt line is high exactly when the source field is nonzero; source numbers offered are nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Offer from a source this cycle |
| req_num | input | NUM_W | Offered source number (nonzero) |
| req_prio | input | PRIO_W | Offered priority |
| op_accept | input | 1 | Take the pending interrupt |
| op_eoi | input | 1 | End of service, status word on op_data |
| op_set_cppr | input | 1 | Write current priority from op_data low bits |
| op_set_mfrr | input | 1 | Write inter-processor priority from op_data low bits |
| op_poll | input | 1 | Read state with no side effect |
| op_data | input | PRIO_W+NUM_W | Operand for the write operations |
| irq_out | output | 1 | Interrupt line to the processor |
| rd_valid | output | 1 | Read data valid (after take or read) |
| rd_word | output | PRIO_W+NUM_W | Returned status word |
| rd_mfrr | output | PRIO_W | Returned inter-processor priority |
| rej_valid | output | 1 | Reject strobe toward sources |
| rej_num | output | NUM_W | Rejected source number |
| eoi_valid | output | 1 | End-of-service strobe toward sources |
| eoi_num | output | NUM_W | Serviced source number |
| resend_req | output | 1 | Ask all sources to re-offer |

## Verification
The bench builds the unit with 4-bit priorities and 8-bit source numbers. This makes the whole 16-by-16 space of current, pending, offered and inter-processor priorities small enough to sweep fully. Every pairing of offer against current priority is covered, as is every offer against an occupied slot. Every inter-processor priority is tried against every current and pending priority that can hold a slot, along with every new current priority against a pending one. The points where equal priorities decide between refuse and accept are reached in each of these sweeps.

// File: rtl/ipres_pkg.sv
package ipres_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_REQ,
    OP_ACCEPT,
    OP_EOI,
    OP_SETCPPR,
    OP_SETMFRR,
    OP_POLL
  } ipres_op_e;

  function automatic ipres_op_e pick_op(input logic req, input logic acc,
                                        input logic eoi, input logic cpr,
                                        input logic mfr, input logic pol);
    ipres_op_e o;
    o = OP_IDLE;
    if (req)      o = OP_REQ;
    else if (acc) o = OP_ACCEPT;
    else if (eoi) o = OP_EOI;
    else if (cpr) o = OP_SETCPPR;
    else if (mfr) o = OP_SETMFRR;
    else if (pol) o = OP_POLL;
    return o;
  endfunction

endpackage

// File: rtl/ipres_admit.sv
module ipres_admit #(
  parameter int PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] req_prio,
  input  logic [PRIO_W-1:0] cppr,
  input  logic [PRIO_W-1:0] pend,
  input  logic              busy,
  output logic              admit
);
  function automatic logic beats(input logic [PRIO_W-1:0] a,
                                 input logic [PRIO_W-1:0] b);
    return a < b;
  endfunction

  // Offer must beat the current priority and, if the slot is taken, the holder.
  assign admit = beats(req_prio, cppr) && !(busy && !beats(req_prio, pend));
endmodule

// File: rtl/ipres_ipi.sv
module ipres_ipi #(
  parameter int PRIO_W = 8
) (
  input  logic              gate,
  input  logic [PRIO_W-1:0] mfrr,
  input  logic [PRIO_W-1:0] cppr,
  input  logic [PRIO_W-1:0] pend,
  input  logic              busy,
  output logic              take
);
  function automatic logic holder_keeps(input logic hb,
                                        input logic [PRIO_W-1:0] hp,
                                        input logic [PRIO_W-1:0] ip);
    return hb && (hp <= ip);
  endfunction

  assign take = gate && (mfrr < cppr) && !holder_keeps(busy, pend, mfrr);
endmodule

// File: rtl/ipres_cppr_eval.sv
module ipres_cppr_eval #(
  parameter int PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] new_cppr,
  input  logic [PRIO_W-1:0] old_cppr,
  input  logic [PRIO_W-1:0] pend,
  input  logic              busy,
  output logic              drop,
  output logic              want_resend
);
  logic tighter;
  assign tighter     = new_cppr < old_cppr;
  assign drop        = tighter && busy && (new_cppr <= pend);
  assign want_resend = !tighter && !busy;
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
  import ipres_pkg::*;
#(
  parameter int PRIO_W  = 8,
  parameter int NUM_W   = 24,
  parameter int IPI_NUM = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [NUM_W-1:0]        req_num,
  input  logic [PRIO_W-1:0]       req_prio,
  input  logic                    op_accept,
  input  logic                    op_eoi,
  input  logic                    op_set_cppr,
  input  logic                    op_set_mfrr,
  input  logic                    op_poll,
  input  logic [PRIO_W+NUM_W-1:0] op_data,
  output logic                    irq_out,
  output logic                    rd_valid,
  output logic [PRIO_W+NUM_W-1:0] rd_word,
  output logic [PRIO_W-1:0]       rd_mfrr,
  output logic                    rej_valid,
  output logic [NUM_W-1:0]        rej_num,
  output logic                    eoi_valid,
  output logic [NUM_W-1:0]        eoi_num,
  output logic                    resend_req
);
  localparam int                WORD_W    = PRIO_W + NUM_W;
  localparam logic [NUM_W-1:0]  IPI_CODE  = NUM_W'(IPI_NUM);
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

  // architectural state
  logic [PRIO_W-1:0] cppr_q, cppr_d;
  logic [NUM_W-1:0]  xisr_q, xisr_d;
  logic [PRIO_W-1:0] pend_q, pend_d;
  logic [PRIO_W-1:0] mfrr_q, mfrr_d;
  logic              owner_q, owner_d;
  logic              irq_q, irq_d;

  // outbound strobes
  logic              rd_v_d, rej_v_d, eoi_v_d, rsnd_d;
  logic [NUM_W-1:0]  rej_n_d, eoi_n_d;
  logic              rd_v_q, rej_v_q, eoi_v_q, rsnd_q;
  logic [NUM_W-1:0]  rej_n_q, eoi_n_q;
  logic [WORD_W-1:0] rd_word_q;
  logic [PRIO_W-1:0] rd_mfrr_q;

  // named internal events
  ipres_op_e         op_w;
  logic              busy_w;
  logic              admit_w;
  logic              drop_w;
  logic              resend_w;
  logic              ipi_gate_w;
  logic              ipi_take_w;
  logic [PRIO_W-1:0] new_prio_w;
  logic [PRIO_W-1:0] eoi_cppr_w;
  logic [PRIO_W-1:0] ipi_cppr_w;
  logic [PRIO_W-1:0] ipi_mfrr_w;

  assign op_w       = pick_op(req_valid, op_accept, op_eoi, op_set_cppr,
                              op_set_mfrr, op_poll);
  assign busy_w     = xisr_q != '0;
  assign new_prio_w = op_data[PRIO_W-1:0];
  assign eoi_cppr_w = op_data[WORD_W-1 -: PRIO_W];

  ipres_admit #(.PRIO_W(PRIO_W)) u_admit (
    .req_prio (req_prio),
    .cppr     (cppr_q),
    .pend     (pend_q),
    .busy     (busy_w),
    .admit    (admit_w)
  );

  ipres_cppr_eval #(.PRIO_W(PRIO_W)) u_cppr (
    .new_cppr    (new_prio_w),
    .old_cppr    (cppr_q),
    .pend        (pend_q),
    .busy        (busy_w),
    .drop        (drop_w),
    .want_resend (resend_w)
  );

  always_comb begin
    ipi_mfrr_w = (op_w == OP_SETMFRR) ? new_prio_w : mfrr_q;
    ipi_cppr_w = cppr_q;
    if (op_w == OP_SETCPPR) ipi_cppr_w = new_prio_w;
    if (op_w == OP_EOI)     ipi_cppr_w = eoi_cppr_w;
  end

  assign ipi_gate_w = (op_w == OP_SETMFRR)
                    || ((op_w == OP_SETCPPR) && resend_w)
                    || ((op_w == OP_EOI) && !busy_w);

  ipres_ipi #(.PRIO_W(PRIO_W)) u_ipi (
    .gate (ipi_gate_w),
    .mfrr (ipi_mfrr_w),
    .cppr (ipi_cppr_w),
    .pend (pend_q),
    .busy (busy_w),
    .take (ipi_take_w)
  );

  always_comb begin
    cppr_d  = cppr_q;
    xisr_d  = xisr_q;
    pend_d  = pend_q;
    mfrr_d  = mfrr_q;
    owner_d = owner_q;
    irq_d   = irq_q;
    rd_v_d  = 1'b0;
    rej_v_d = 1'b0;
    rej_n_d = '0;
    eoi_v_d = 1'b0;
    eoi_n_d = '0;
    rsnd_d  = 1'b0;
    unique case (op_w)
      OP_REQ: begin
        if (admit_w) begin
          if (busy_w && owner_q) begin
            rej_v_d = 1'b1;
            rej_n_d = xisr_q;
          end
          xisr_d  = req_num;
          pend_d  = req_prio;
          owner_d = 1'b1;
          irq_d   = 1'b1;
        end else begin
          rej_v_d = 1'b1;
          rej_n_d = req_num;
        end
      end
      OP_ACCEPT: begin
        rd_v_d  = 1'b1;
        cppr_d  = pend_q;
        xisr_d  = '0;
        pend_d  = PRIO_NONE;
        owner_d = 1'b0;
        irq_d   = 1'b0;
      end
      OP_POLL: rd_v_d = 1'b1;
      OP_SETCPPR: begin
        cppr_d = new_prio_w;
        if (drop_w) begin
          if (owner_q) begin
            rej_v_d = 1'b1;
            rej_n_d = xisr_q;
          end
          xisr_d  = '0;
          pend_d  = PRIO_NONE;
          owner_d = 1'b0;
          irq_d   = 1'b0;
        end
        if (resend_w) rsnd_d = 1'b1;
      end
      OP_SETMFRR: mfrr_d = new_prio_w;
      OP_EOI: begin
        cppr_d  = eoi_cppr_w;
        eoi_v_d = 1'b1;
        eoi_n_d = op_data[NUM_W-1:0];
        if (!busy_w) rsnd_d = 1'b1;
      end
      default: ;
    endcase
    if (ipi_take_w) begin
      if (busy_w && owner_q) begin
        rej_v_d = 1'b1;
        rej_n_d = xisr_q;
      end
      xisr_d  = IPI_CODE;
      pend_d  = ipi_mfrr_w;
      owner_d = 1'b0;
      irq_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cppr_q    <= '0;
      xisr_q    <= '0;
      pend_q    <= PRIO_NONE;
      mfrr_q    <= PRIO_NONE;
      owner_q   <= 1'b0;
      irq_q     <= 1'b0;
      rd_v_q    <= 1'b0;
      rej_v_q   <= 1'b0;
      rej_n_q   <= '0;
      eoi_v_q   <= 1'b0;
      eoi_n_q   <= '0;
      rsnd_q    <= 1'b0;
      rd_word_q <= '0;
      rd_mfrr_q <= PRIO_NONE;
    end else begin
      cppr_q  <= cppr_d;
      xisr_q  <= xisr_d;
      pend_q  <= pend_d;
      mfrr_q  <= mfrr_d;
      owner_q <= owner_d;
      irq_q   <= irq_d;
      rd_v_q  <= rd_v_d;
      rej_v_q <= rej_v_d;
      rej_n_q <= rej_n_d;
      eoi_v_q <= eoi_v_d;
      eoi_n_q <= eoi_n_d;
      rsnd_q  <= rsnd_d;
      if (rd_v_d) begin
        rd_word_q <= {cppr_q, xisr_q};
        rd_mfrr_q <= mfrr_q;
      end
    end
  end

  assign irq_out    = irq_q;
  assign rd_valid   = rd_v_q;
  assign rd_word    = rd_word_q;
  assign rd_mfrr    = rd_mfrr_q;
  assign rej_valid  = rej_v_q;
  assign rej_num    = rej_n_q;
  assign eoi_valid  = eoi_v_q;
  assign eoi_num    = eoi_n_q;
  assign resend_req = rsnd_q;

  // ---------------- assertions ----------------
  p_single_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({req_valid, op_accept, op_eoi, op_set_cppr, op_set_mfrr, op_poll}) <= 1);

  p_line_tracks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (xisr_q != '0));

  p_poll_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_w == OP_POLL) |=> ($stable(cppr_q) && $stable(xisr_q) && $stable(mfrr_q)
                           && rd_valid && !rej_valid));

  p_refuse_echo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_w == OP_REQ && !admit_w) |=> (rej_valid && rej_num == $past(req_num)
                                      && $stable(xisr_q)));

  p_admit_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_w == OP_REQ && admit_w) |=> (irq_out && xisr_q == $past(req_num)));

  p_take_lowers_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_w == OP_ACCEPT) |=> (!irq_out && xisr_q == '0 && rd_valid
                             && cppr_q == $past(pend_q)));

  p_drop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_w == OP_SETCPPR && drop_w) |=> (!irq_out && xisr_q == '0));

  p_resend_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_w == OP_SETCPPR && resend_w) |=> resend_req);

  p_eoi_forward_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_w == OP_EOI) |=> (eoi_valid && eoi_num == $past(op_data[NUM_W-1:0])));

  p_ipi_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_take_w |=> (irq_out && xisr_q == IPI_CODE));

  p_ipi_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_w == OP_SETMFRR && busy_w && pend_q <= new_prio_w)
      |=> ($stable(xisr_q) && !rej_valid));

endmodule

// File: tb/irq_presenter_test.sv
`timescale 1ns/1ps
module irq_presenter_test;
  localparam int PW = 4;
  localparam int NW = 8;
  localparam int WW = PW + NW;
  localparam int K_REQ = 0, K_ACC = 1, K_EOI = 2, K_CPPR = 3, K_MFRR = 4, K_POLL = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [NW-1:0] req_num = '0;
  logic [PW-1:0] req_prio = '0;
  logic          op_accept = 1'b0, op_eoi = 1'b0, op_set_cppr = 1'b0;
  logic          op_set_mfrr = 1'b0, op_poll = 1'b0;
  logic [WW-1:0] op_data = '0;
  logic          irq_out, rd_valid, rej_valid, eoi_valid, resend_req;
  logic [WW-1:0] rd_word;
  logic [PW-1:0] rd_mfrr;
  logic [NW-1:0] rej_num, eoi_num;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // sampled after each operation
  logic          s_rej_v, s_eoi_v, s_rsnd, s_rd_v, s_irq;
  logic [NW-1:0] s_rej_n, s_eoi_n;
  logic [WW-1:0] s_word;
  logic [PW-1:0] s_mfrr;

  irq_presenter #(.PRIO_W(PW), .NUM_W(NW), .IPI_NUM(2)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_num(req_num),
    .req_prio(req_prio), .op_accept(op_accept), .op_eoi(op_eoi),
    .op_set_cppr(op_set_cppr), .op_set_mfrr(op_set_mfrr), .op_poll(op_poll),
    .op_data(op_data), .irq_out(irq_out), .rd_valid(rd_valid), .rd_word(rd_word),
    .rd_mfrr(rd_mfrr), .rej_valid(rej_valid), .rej_num(rej_num),
    .eoi_valid(eoi_valid), .eoi_num(eoi_num), .resend_req(resend_req)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int word(input int c, input int n);
    return c * (1 << NW) + n;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drive(input int k, input int data, input int num, input int prio);
    @(negedge clk);
    op_data  = WW'(data);
    req_num  = NW'(num);
    req_prio = PW'(prio);
    case (k)
      K_REQ:  req_valid   = 1'b1;
      K_ACC:  op_accept   = 1'b1;
      K_EOI:  op_eoi      = 1'b1;
      K_CPPR: op_set_cppr = 1'b1;
      K_MFRR: op_set_mfrr = 1'b1;
      default: op_poll    = 1'b1;
    endcase
    @(negedge clk);
    {req_valid, op_accept, op_eoi, op_set_cppr, op_set_mfrr, op_poll} = '0;
    s_rej_v = rej_valid;  s_rej_n = rej_num;
    s_eoi_v = eoi_valid;  s_eoi_n = eoi_num;
    s_rsnd  = resend_req; s_rd_v  = rd_valid;
    s_word  = rd_word;    s_mfrr  = rd_mfrr;
    s_irq   = irq_out;
  endtask

  task automatic req(input int n, input int p);  drive(K_REQ, 0, n, p);  endtask
  task automatic set_cppr(input int v);          drive(K_CPPR, v, 0, 0); endtask
  task automatic set_mfrr(input int v);          drive(K_MFRR, v, 0, 0); endtask
  task automatic poll();                         drive(K_POLL, 0, 0, 0); endtask
  task automatic take();                         drive(K_ACC, 0, 0, 0);  endtask
  task automatic eoi(input int w);               drive(K_EOI, w, 0, 0);  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 line low", int'(irq_out), 0);
    chk("R1 no reject", int'(rej_valid), 0);
    poll();
    chk("R1 word zero", int'(s_word), 0);
    chk("R1 mfrr ones", int'(s_mfrr), 15);
    // R2 read has no side effect
    chk("R2 rd_valid", int'(s_rd_v), 1);
    poll();
    chk("R2 repeat word", int'(s_word), 0);
    chk("R2 no strobes", int'(s_rej_v | s_rsnd | s_eoi_v), 0);
    take();
    chk("R5 take after reset returns", int'(s_word), 0);
    poll();
    chk("R1 pending prio ones", int'(s_word), word(15, 0));

    // R3/R4 offer versus current priority, all pairs
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 16; p++) begin
        do_reset();
        set_cppr(c);
        req(8'h80 + p, p);
        chk("R3 reject flag", int'(s_rej_v), (p >= c) ? 1 : 0);
        if (p >= c) chk("R3 reject num", int'(s_rej_n), 8'h80 + p);
        chk("R4 line", int'(s_irq), (p < c) ? 1 : 0);
        poll();
        chk("R2 word layout", int'(s_word), word(c, (p < c) ? 8'h80 + p : 0));
      end
    end

    // R3/R4/R5 offer versus occupied slot, then take twice
    for (int q = 0; q < 15; q++) begin
      for (int p = 0; p < 15; p++) begin
        int win, lose, best;
        win  = (p < q) ? 8'hA0 : 8'h90;
        lose = (p < q) ? 8'h90 : 8'hA0;
        best = (p < q) ? p : q;
        do_reset();
        set_cppr(15);
        req(8'h90, q);
        req(8'hA0, p);
        chk("R3 R4 reject strobe", int'(s_rej_v), 1);
        chk("R3 R4 reject num", int'(s_rej_n), lose);
        take();
        chk("R5 take returns", int'(s_word), word(15, win));
        chk("R5 line low", int'(s_irq), 0);
        poll();
        chk("R5 cppr from pending", int'(s_word), word(best, 0));
        take();
        poll();
        chk("R5 pending reset", int'(s_word), word(15, 0));
      end
    end

    // R9/R10 inter-processor priority against empty and occupied slot
    for (int c = 1; c < 16; c++) begin
      for (int m = 0; m < 16; m++) begin
        do_reset();
        set_cppr(c);
        set_mfrr(m);
        chk("R9 line", int'(s_irq), (m < c) ? 1 : 0);
        poll();
        chk("R9 ipi word", int'(s_word), word(c, (m < c) ? 2 : 0));
        chk("R9 mfrr readback", int'(s_mfrr), m);
        for (int q = 0; q < c; q++) begin
          do_reset();
          set_cppr(c);
          req(8'h90, q);
          set_mfrr(m);
          chk("R9 R10 reject", int'(s_rej_v), (m < q) ? 1 : 0);
          if (m < q) chk("R9 reject num", int'(s_rej_n), 8'h90);
          poll();
          chk("R10 slot", int'(s_word), word(c, (m < q) ? 2 : 8'h90));
        end
      end
    end

    // R4 displaced inter-processor interrupt is not rejected
    do_reset();
    set_cppr(15);
    set_mfrr(9);
    req(8'h55, 3);
    chk("R4 ipi displaced silently", int'(s_rej_v), 0);
    poll();
    chk("R4 new holder", int'(s_word), word(15, 8'h55));

    // R6 tightening the current priority over an occupied slot
    for (int v = 0; v < 16; v++) begin
      for (int q = 0; q < 15; q++) begin
        bit dropit;
        dropit = (v < 15) && (v <= q);
        do_reset();
        set_cppr(15);
        req(8'h90, q);
        set_cppr(v);
        chk("R6 reject", int'(s_rej_v), dropit ? 1 : 0);
        if (dropit) chk("R6 reject num", int'(s_rej_n), 8'h90);
        chk("R6 line", int'(s_irq), dropit ? 0 : 1);
        chk("R7 no resend while busy", int'(s_rsnd), 0);
        poll();
        chk("R6 word", int'(s_word), word(v, dropit ? 0 : 8'h90));
      end
    end
    // R6 dropping an inter-processor interrupt sends no reject
    do_reset();
    set_cppr(10);
    set_mfrr(6);
    set_cppr(4);
    chk("R6 ipi no reject", int'(s_rej_v), 0);
    chk("R6 ipi line low", int'(s_irq), 0);

    // R7 loosening with empty slot
    do_reset();
    set_cppr(4);
    chk("R7 resend on loosen", int'(s_rsnd), 1);
    set_mfrr(6);
    chk("R7 mfrr above cppr idle", int'(s_irq), 0);
    set_cppr(9);
    chk("R7 resend", int'(s_rsnd), 1);
    chk("R7 ipi loaded", int'(s_irq), 1);
    poll();
    chk("R7 word", int'(s_word), word(9, 2));
    set_cppr(3);
    chk("R7 tighten no resend", int'(s_rsnd), 0);

    // R8 end of service against each new current priority
    for (int e = 0; e < 16; e++) begin
      do_reset();
      set_mfrr(8);
      eoi(word(e, 8'h3C));
      chk("R8 eoi strobe", int'(s_eoi_v), 1);
      chk("R8 eoi num", int'(s_eoi_n), 8'h3C);
      chk("R8 resend", int'(s_rsnd), 1);
      poll();
      chk("R8 cppr copy", int'(s_word), word(e, (8 < e) ? 2 : 0));
    end
    do_reset();
    set_cppr(12);
    req(8'h71, 5);
    eoi(word(7, 8'h44));
    chk("R8 no resend while busy", int'(s_rsnd), 0);
    poll();
    chk("R8 holder kept", int'(s_word), word(7, 8'h71));
    chk("R11 line matches field", int'(irq_out), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule